// File: doc/BRIEF.md
# FSK Staircase Frequency-Word Generator

This block forms the frequency control word for a fractional-N synthesizer in a narrowband two-tone FSK transmitter. The carrier is given as an integer part and a 20-bit fraction, together read as N + F/2^20. The fraction arrives in three fields: a low byte, a middle byte and a 4-bit top field. For example, a fraction of 0x64EC4 splits as top 0x6, middle 0x4E and low 0xC4. At a 26 MHz reference, one fraction LSB is worth about 25 Hz.

A serial data bit chooses the high or the low tone. When the bit changes, the word does not jump. It walks a ladder of ten offset levels built from five programmable deviation magnitudes, taken with both signs. The time spent on each rung comes from a transition-time setting. That setting counts in units of four reference clocks, and one ladder half of five rungs covers that time. Typical settings are 0xFF at 2400 bps, 0x87 at 4800 bps and 0x5A at 7200 bps.

When the block is disabled, it emits the bare carrier word, giving a CW tone. A flag output is high while the word is still walking toward the tone the data bit asks for. All register storage sits outside the block, and its contents reach the block as static inputs.

Top module: `fsk_stair_word`

## Requirements
- R1: `freq_word` is the concatenation {`chan_int`, `frac_hi`, `frac_mid`, `frac_lo`} (fraction bits 19:16, 15:8 and 7:0) plus the sign-extended offset of the current level. The sum wraps modulo 2^28, so a negative offset borrows from the integer part.
- R2: There are ten levels, numbered 0 to 9. Levels 0..4 carry offsets -D4, -D3, -D2, -D1, -D0, and levels 5..9 carry +D0..+D4, where Dk is `dev_steps[8k+7:8k]`. A data bit of 1 targets level 9 and a data bit of 0 targets level 0.
- R3: The rung hold time is S = max(1, floor(T*4/5)), where T is `trans_time`. Count the first rising edge that samples a new data value as edge 1. The level then moves one rung toward the target on edges 1+S, 1+2S, and so on, and never moves more than one rung per edge.
- R4: On an edge where the sampled data bit differs from the bit sampled on the previous edge, the level holds and the rung count restarts. A reversal in mid-walk therefore resumes from the rung already reached.
- R5: While `enable` is low, each edge loads `freq_word` with the bare carrier word and drives `shaping` low. Each such edge also sets the level to the target of the current data bit, so the block restarts settled on that tone when it is re-enabled.
- R6: After each enabled edge, `shaping` is high exactly when the level differs from the target of the data bit sampled on that edge.
- R7: Reset is asynchronous and active low. It clears `freq_word` and `shaping` to zero and puts the level at 0.
- R8: `freq_word` and `shaping` are registered. A change on the carrier inputs shows at the output after one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Modulation enable; low gives CW |
| tx_bit | input | 1 | Serial data bit selecting the tone |
| chan_int | input | 8 | Integer part of the carrier |
| frac_lo | input | 8 | Fraction bits 7:0 |
| frac_mid | input | 8 | Fraction bits 15:8 |
| frac_hi | input | 4 | Fraction bits 19:16 |
| dev_steps | input | 40 | Five deviation magnitudes, D0 in the low byte |
| trans_time | input | 8 | Transition-time setting, in units of 4 clocks |
| freq_word | output | 28 | Registered synthesizer frequency word |
| shaping | output | 1 | High while the level is walking toward its target |

## Verification
The checker assumes that `enable` and `tx_bit` are synchronous to `clk`. It also assumes that the deviation magnitudes and the transition time do not change in the middle of a walk, so that a rung-to-rung step and the flag relation can be judged from one edge to the next.

The stimulus drives every input on the falling clock edge. It changes the deviation and timing inputs only while the level is settled. It also reverses the data bit in mid-walk, with the rung count partly advanced, to exercise the restart.

// File: rtl/fskw_pkg.sv
package fskw_pkg;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } walk_dir_e;

  // Cycles spent on one rung: setting * clocks-per-unit spread over the rungs of one half.
  function automatic int unsigned rung_hold(input int unsigned setting,
                                            input int unsigned per_unit,
                                            input int unsigned rungs);
    int unsigned q;
    q = (setting * per_unit) / rungs;
    return (q == 0) ? 1 : q;
  endfunction

  // Highest level index of a ladder built from 'rungs' magnitudes on each side.
  function automatic int unsigned ladder_top(input int unsigned rungs);
    return 2 * rungs - 1;
  endfunction

endpackage

// File: rtl/fskw_step_timer.sv
module fskw_step_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic             moving,
  input  logic [CNT_W-1:0] hold,
  output logic             step
);

  logic [CNT_W-1:0] cnt_q;

  assign step = en && !restart && moving && (cnt_q == hold - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   cnt_q <= '0;
    else if (!en || restart || !moving || step)   cnt_q <= '0;
    else                                          cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/fskw_level_walker.sv
module fskw_level_walker
  import fskw_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int TOP   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bit_i,
  input  logic             step,
  output logic [LVL_W-1:0] lvl_q,
  output logic [LVL_W-1:0] lvl_nxt,
  output logic [LVL_W-1:0] tgt_lvl,
  output logic             data_chg,
  output logic             moving
);

  localparam logic [LVL_W-1:0] TOP_L = LVL_W'(TOP);

  logic      data_q;
  walk_dir_e dir;

  assign tgt_lvl  = bit_i ? TOP_L : '0;
  assign moving   = (lvl_q != tgt_lvl);
  assign data_chg = (bit_i != data_q);

  always_comb begin
    if (!moving)                dir = DIR_HOLD;
    else if (tgt_lvl > lvl_q)   dir = DIR_UP;
    else                        dir = DIR_DOWN;
  end

  always_comb begin
    lvl_nxt = lvl_q;
    if (!en) begin
      lvl_nxt = tgt_lvl;
    end else if (step) begin
      unique case (dir)
        DIR_UP:   lvl_nxt = lvl_q + LVL_W'(1);
        DIR_DOWN: lvl_nxt = lvl_q - LVL_W'(1);
        default:  lvl_nxt = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      data_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_nxt;
      data_q <= bit_i;
    end
  end

endmodule

// File: rtl/fskw_word_out.sv
module fskw_word_out #(
  parameter int W     = 28,
  parameter int DEV_W = 8,
  parameter int STEPS = 5,
  parameter int LVL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [W-1:0]           base,
  input  logic [STEPS*DEV_W-1:0] dev,
  input  logic [LVL_W-1:0]       lvl_nxt,
  input  logic                   busy_nxt,
  output logic [W-1:0]           word_q,
  output logic                   busy_q
);

  localparam int LEVELS = 2 * STEPS;
  localparam int OFF_W  = DEV_W + 1;

  logic signed [OFF_W-1:0] off_tab [LEVELS];
  logic signed [OFF_W-1:0] off_sel;
  logic        [W-1:0]     word_nxt;

  function automatic logic [W-1:0] add_offset(input logic [W-1:0] b,
                                              input logic signed [OFF_W-1:0] o);
    logic [W-1:0] ext;
    ext = {{(W-OFF_W){o[OFF_W-1]}}, o};
    return b + ext;
  endfunction

  for (genvar g = 0; g < STEPS; g++) begin : g_ladder
    assign off_tab[g]         = -$signed({1'b0, dev[(STEPS-1-g)*DEV_W +: DEV_W]});
    assign off_tab[STEPS + g] =  $signed({1'b0, dev[g*DEV_W +: DEV_W]});
  end

  always_comb begin
    off_sel = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (lvl_nxt == LVL_W'(k)) off_sel = off_tab[k];
    end
  end

  assign word_nxt = add_offset(base, off_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      busy_q <= 1'b0;
    end else begin
      word_q <= en ? word_nxt : base;
      busy_q <= busy_nxt;
    end
  end

endmodule

// File: rtl/fsk_stair_word.sv
module fsk_stair_word
  import fskw_pkg::*;
#(
  parameter int N_W       = 8,
  parameter int BYTE_W    = 8,
  parameter int FRAC_HI_W = 4,
  parameter int DEV_W     = 8,
  parameter int STEPS     = 5,
  parameter int TT_W      = 8,
  parameter int PER_UNIT  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic                       tx_bit,
  input  logic [N_W-1:0]             chan_int,
  input  logic [BYTE_W-1:0]          frac_lo,
  input  logic [BYTE_W-1:0]          frac_mid,
  input  logic [FRAC_HI_W-1:0]       frac_hi,
  input  logic [STEPS*DEV_W-1:0]     dev_steps,
  input  logic [TT_W-1:0]            trans_time,
  output logic [N_W+2*BYTE_W+FRAC_HI_W-1:0] freq_word,
  output logic                       shaping
);

  localparam int F_W   = 2 * BYTE_W + FRAC_HI_W;
  localparam int W     = N_W + F_W;
  localparam int TOP   = ladder_top(STEPS);
  localparam int LVL_W = $clog2(TOP + 1);
  localparam int CNT_W = TT_W + $clog2(PER_UNIT) + 1;

  logic [W-1:0]     base_word;
  logic [CNT_W-1:0] hold_len;
  logic [LVL_W-1:0] lvl_q, lvl_nxt, tgt_lvl;
  logic             data_chg, moving, step, busy_nxt;

  assign base_word = {chan_int, frac_hi, frac_mid, frac_lo};
  assign hold_len  = CNT_W'(rung_hold(32'(trans_time), PER_UNIT, STEPS));
  assign busy_nxt  = enable && (lvl_nxt != tgt_lvl);

  fskw_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(enable), .restart(data_chg),
    .moving(moving), .hold(hold_len), .step(step)
  );

  fskw_level_walker #(.LVL_W(LVL_W), .TOP(TOP)) u_walker (
    .clk(clk), .rst_n(rst_n), .en(enable), .bit_i(tx_bit), .step(step),
    .lvl_q(lvl_q), .lvl_nxt(lvl_nxt), .tgt_lvl(tgt_lvl),
    .data_chg(data_chg), .moving(moving)
  );

  fskw_word_out #(.W(W), .DEV_W(DEV_W), .STEPS(STEPS), .LVL_W(LVL_W)) u_out (
    .clk(clk), .rst_n(rst_n), .en(enable), .base(base_word), .dev(dev_steps),
    .lvl_nxt(lvl_nxt), .busy_nxt(busy_nxt), .word_q(freq_word), .busy_q(shaping)
  );

endmodule

// File: rtl/fsk_stair_word_chk.sv
module fsk_stair_word_chk #(
  parameter int W     = 28,
  parameter int LVL_W = 4,
  parameter int TOP   = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             data,
  input logic [W-1:0]     base,
  input logic [W-1:0]     freq,
  input logic             busy,
  input logic [LVL_W-1:0] lvl,
  input logic             data_chg
);

  localparam logic [LVL_W-1:0] TOP_L = LVL_W'(TOP);

  AST_CW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (freq == $past(base)));  // R5

  AST_FLAG_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);  // R5

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= TOP_L);  // R2

  AST_SINGLE_RUNG: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (lvl == $past(lvl) || lvl == $past(lvl) + LVL_W'(1) ||
            lvl + LVL_W'(1) == $past(lvl)));  // R3

  AST_HOLD_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && data_chg) |=> $stable(lvl));  // R4

  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (busy == (lvl != ($past(data) ? TOP_L : '0))));  // R6

endmodule

bind fsk_stair_word fsk_stair_word_chk #(.W(W), .LVL_W(LVL_W), .TOP(TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(enable), .data(tx_bit), .base(base_word),
  .freq(freq_word), .busy(shaping), .lvl(lvl_q), .data_chg(data_chg)
);

// File: tb/fsk_stair_word_tb.sv
module fsk_stair_word_tb;

  localparam int W = 28;

  typedef struct packed {
    logic       en;
    logic       d;
    logic [7:0] n;
    logic [3:0] lvl;   // 15 means bare carrier expected
    logic       busy;
  } vec_t;

  // Hold S = floor(5*4/5) = 4 cycles per rung.
  localparam vec_t VEC [15] = '{
    '{1'b1, 1'b0, 8'd3,  4'd0,  1'b0},  // R2 settled low
    '{1'b1, 1'b1, 8'd1,  4'd0,  1'b1},  // R4 change edge holds
    '{1'b1, 1'b1, 8'd4,  4'd1,  1'b1},  // R3 first rung at edge 1+S
    '{1'b1, 1'b1, 8'd4,  4'd2,  1'b1},  // R3
    '{1'b1, 1'b1, 8'd12, 4'd5,  1'b1},  // R2 crosses zero to +D0
    '{1'b1, 1'b1, 8'd16, 4'd9,  1'b0},  // R6 flag drops at top
    '{1'b1, 1'b1, 8'd5,  4'd9,  1'b0},  // R2 settled high
    '{1'b1, 1'b0, 8'd7,  4'd8,  1'b1},  // R3 walking down
    '{1'b1, 1'b1, 8'd2,  4'd8,  1'b1},  // R4 reversal restarts count
    '{1'b1, 1'b1, 8'd3,  4'd9,  1'b0},  // R4 resume from reached rung
    '{1'b0, 1'b0, 8'd1,  4'd15, 1'b0},  // R5 CW when off
    '{1'b1, 1'b0, 8'd2,  4'd0,  1'b0},  // R5 re-enable settled
    '{1'b1, 1'b1, 8'd6,  4'd1,  1'b1},  // R3
    '{1'b0, 1'b1, 8'd1,  4'd15, 1'b0},  // R5 off mid-walk
    '{1'b1, 1'b1, 8'd1,  4'd9,  1'b0}   // R5 snapped to high tone
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        tx_bit = 1'b0;
  logic [7:0]  chan_int = 8'h10;
  logic [7:0]  frac_lo = 8'hC4;
  logic [7:0]  frac_mid = 8'h4E;
  logic [3:0]  frac_hi = 4'h6;
  logic [39:0] dev_steps = {8'h54, 8'h50, 8'h44, 8'h31, 8'h1A};
  logic [7:0]  trans_time = 8'd5;
  logic [W-1:0] freq_word;
  logic        shaping;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fsk_stair_word u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tx_bit(tx_bit),
    .chan_int(chan_int), .frac_lo(frac_lo), .frac_mid(frac_mid), .frac_hi(frac_hi),
    .dev_steps(dev_steps), .trans_time(trans_time),
    .freq_word(freq_word), .shaping(shaping)
  );

  function automatic logic [W-1:0] carrier();
    return {chan_int, frac_hi, frac_mid, frac_lo};
  endfunction

  // Level k: below the middle the k-th magnitude from the top, negated; above it positive.
  function automatic logic [W-1:0] expect_word(input int lvl);
    int off;
    if (lvl == 15) return carrier();
    if (lvl >= 5) off = int'(dev_steps[(lvl-5)*8 +: 8]);
    else          off = -int'(dev_steps[(4-lvl)*8 +: 8]);
    return carrier() + W'(off);
  endfunction

  task automatic check_out(input string req, input logic [W-1:0] exp_w, input logic exp_b);
    total++;
    if (freq_word !== exp_w || shaping !== exp_b) begin
      bad++;
      $display("FAIL %s: word=%h busy=%b expected word=%h busy=%b",
               req, freq_word, shaping, exp_w, exp_b);
    end
  endtask

  task automatic run_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R7 reset state
    run_edges(3);
    check_out("R7", '0, 1'b0);
    rst_n = 1'b1;
    enable = 1'b1;

    // R1 R2 R3 R4 R5 R6 vector walk
    foreach (VEC[i]) begin
      enable = VEC[i].en;
      tx_bit = VEC[i].d;
      run_edges(int'(VEC[i].n));
      check_out($sformatf("R2/R3/R4/R5/R6 vec%0d", i), expect_word(int'(VEC[i].lvl)), VEC[i].busy);
    end

    // R3 minimum hold: setting 1 gives S=1
    trans_time = 8'd1;
    tx_bit = 1'b0;
    run_edges(3);
    check_out("R3 min hold", expect_word(7), 1'b1);
    run_edges(7);
    check_out("R3 min hold end", expect_word(0), 1'b0);

    // R1 R8 borrow into integer part, seen one edge later
    frac_lo = 8'h10; frac_mid = 8'h00; frac_hi = 4'h0;
    run_edges(1);
    check_out("R1 R8 borrow", 28'h0FFFFBC, 1'b0);
    total++;
    if (freq_word[27:20] !== 8'h0F) begin
      bad++;
      $display("FAIL R1: integer part=%h expected=%h", freq_word[27:20], 8'h0F);
    end

    // R3 long hold: setting 0xFF gives S=204
    trans_time = 8'hFF;
    frac_lo = 8'hC4; frac_mid = 8'h4E; frac_hi = 4'h6;
    tx_bit = 1'b1;
    run_edges(204);
    check_out("R3 long hold before", expect_word(0), 1'b1);
    run_edges(1);
    check_out("R3 long hold step", expect_word(1), 1'b1);

    // R7 reset in mid-walk
    rst_n = 1'b0;
    #1;
    check_out("R7 async", '0, 1'b0);
    run_edges(1);
    check_out("R7 held", '0, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule